// File: doc/BRIEF.md
# Interlaced YUV Video Timing Generator

This block produces the raster timing and the component byte stream for an 8-bit interlaced video link that feeds a TV encoder. One pixel clock drives everything. On each clock of an active line it can carry one Y, U or V byte, which it takes from an upstream ready/valid source. Three active-low strobes go with the bytes: a line strobe, a field strobe and a data-ready qualifier.

Line length, active width, lines per field, field-strobe width and the mid-line offset of the even-field strobe are all inputs. The block captures them only when a frame starts. A frame is an odd field followed by an even field. The receiver tells the two apart by where the field strobe falls within the line. For an odd field it falls on the same clock as the line strobe. For an even field it falls a programmed number of clocks later.

Top module: `yuv_field_timer`

## Requirements
- R1: While rst_ni is low, hsync_no, vsync_no and drdy_no are 1, disp_bus_o is 0 and pix_ready_o is 0; the first line after reset starts an odd field.
- R2: hsync_no is 0 for exactly one clock at the start of every line, and consecutive lines start line_len clocks apart.
- R3: pix_ready_o is 1 for the active_len clocks that directly follow the clock on which the line counter is at position 0, and 0 for the rest of the line. This makes every transferred byte appear while hsync_no is 1.
- R4: A byte accepted on a clock (pix_valid_i and pix_ready_o both 1) appears on the next clock on disp_bus_o[17:10], with pix_data_i bit 7 on bus bit 17 down to bit 0 on bus bit 10. disp_bus_o[9:0] is always 0.
- R5: drdy_no is 0 exactly on clocks that carry an accepted byte. On every other clock, including active clocks with no valid byte, drdy_no is 1 and disp_bus_o is 0.
- R6: Entering an odd field, vsync_no falls on the same clock as hsync_no on the first line of that field.
- R7: Entering an even field, vsync_no falls vs_offset_i clocks after the hsync_no falling edge of the field's first line. An offset of 0 is treated as 1, so the two edges never coincide.
- R8: vsync_no stays 0 for vs_width_i clocks; a width of 0 is treated as 1.
- R9: field_odd_o is 1 through each odd field and 0 through each even field. It changes on the clock where the first line of the field starts, and each field lasts field_lines_i lines.
- R10: The timing inputs are captured only at the start of a frame, meaning the first line of an odd field. A change made in the middle of a frame has no effect on the outputs until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_len_i | input | 12 | Clocks per line, including the line-strobe clock |
| active_len_i | input | 12 | Byte slots per line, less than line_len_i |
| field_lines_i | input | 11 | Lines per field |
| vs_width_i | input | 12 | Field-strobe low width in clocks (0 acts as 1) |
| vs_offset_i | input | 12 | Even-field strobe offset from line start (0 acts as 1) |
| pix_data_i | input | 8 | Upstream component byte |
| pix_valid_i | input | 1 | Upstream byte valid |
| pix_ready_o | output | 1 | Block accepts a byte this clock |
| disp_bus_o | output | 18 | Output bus, byte on bits 17:10 |
| hsync_no | output | 1 | Line strobe, active low |
| vsync_no | output | 1 | Field strobe, active low |
| drdy_no | output | 1 | Data qualifier, active low |
| field_odd_o | output | 1 | 1 during an odd field |

## Verification
pix_ready_o is combinational from the raster position, so it is checked in the same clock as that position. The strobes, the parity bit, the data qualifier and the bus are all registered, so they reflect the position, and any byte accepted there, exactly one clock later. For each clock, the bench pushes an expected item into a queue, built from a raster model that follows the requirements. On the next clock's falling edge the monitor pops that item and compares it with the outputs. The bench drives the timing inputs from the same model, including a change made in mid-frame, so that the moment the new values are captured is checked as well.

// File: rtl/yuv_tmg_pkg.sv
package yuv_tmg_pkg;
  parameter int unsigned COL_W = 12;
  parameter int unsigned ROW_W = 11;
  parameter int unsigned PIX_W = 8;

  typedef struct packed {
    logic [COL_W-1:0] line_len;
    logic [COL_W-1:0] active_len;
    logic [ROW_W-1:0] rows;
    logic [COL_W-1:0] vs_wid;
    logic [COL_W-1:0] vs_off;
  } tmg_cfg_t;
endpackage

// File: rtl/tmg_raster_cnt.sv
module tmg_raster_cnt
  import yuv_tmg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tmg_cfg_t         cfg_i,
  output logic             run_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             odd_o,
  output tmg_cfg_t         shd_o
);
  logic col_last, row_last;

  assign col_last = (col_o == shd_o.line_len - 1'b1);
  assign row_last = (row_o == shd_o.rows - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o <= 1'b0;
      col_o <= '0;
      row_o <= '0;
      odd_o <= 1'b1;
      shd_o <= '0;
    end else if (!run_o) begin
      run_o <= 1'b1;
      col_o <= '0;
      row_o <= '0;
      odd_o <= 1'b1;
      shd_o <= cfg_i;
    end else if (col_last) begin
      col_o <= '0;
      if (row_last) begin
        row_o <= '0;
        odd_o <= ~odd_o;
        // even -> odd: new frame, capture timing
        if (!odd_o) shd_o <= cfg_i;
      end else begin
        row_o <= row_o + 1'b1;
      end
    end else begin
      col_o <= col_o + 1'b1;
    end
  end
endmodule

// File: rtl/tmg_sync_gen.sv
module tmg_sync_gen
  import yuv_tmg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             odd_i,
  input  tmg_cfg_t         shd_i,
  output logic             hsync_no,
  output logic             vsync_no,
  output logic             field_odd_o
);
  logic [COL_W-1:0] off_eff, wid_eff, vs_left;
  logic             vs_start, vs_col;

  assign off_eff  = (shd_i.vs_off == '0) ? COL_W'(1) : shd_i.vs_off;
  assign wid_eff  = (shd_i.vs_wid == '0) ? COL_W'(1) : shd_i.vs_wid;
  assign vs_col   = odd_i ? (col_i == '0) : (col_i == off_eff);
  assign vs_start = run_i && (row_i == '0) && vs_col;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_left     <= '0;
      hsync_no    <= 1'b1;
      vsync_no    <= 1'b1;
      field_odd_o <= 1'b1;
    end else begin
      if (vs_start)            vs_left <= wid_eff - 1'b1;
      else if (vs_left != '0)  vs_left <= vs_left - 1'b1;
      hsync_no    <= ~(run_i && (col_i == '0));
      vsync_no    <= ~(vs_start || (vs_left != '0));
      field_odd_o <= odd_i;
    end
  end
endmodule

// File: rtl/tmg_pix_path.sv
module tmg_pix_path
  import yuv_tmg_pkg::*;
#(
  parameter int unsigned BUS_LSB = 10,
  localparam int unsigned BUS_W  = BUS_LSB + PIX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] act_len_i,
  input  logic [PIX_W-1:0] pix_data_i,
  input  logic             pix_valid_i,
  output logic             pix_ready_o,
  output logic [BUS_W-1:0] bus_o,
  output logic             drdy_no
);
  logic xfer;

  assign pix_ready_o = run_i && (col_i != '0) && (col_i <= act_len_i);
  assign xfer        = pix_ready_o && pix_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_o   <= '0;
      drdy_no <= 1'b1;
    end else begin
      bus_o <= '0;
      if (xfer) bus_o[BUS_LSB +: PIX_W] <= pix_data_i;
      drdy_no <= ~xfer;
    end
  end
endmodule

// File: rtl/yuv_field_timer.sv
module yuv_field_timer
  import yuv_tmg_pkg::*;
#(
  parameter int unsigned BUS_LSB = 10,
  localparam int unsigned BUS_W  = BUS_LSB + PIX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [COL_W-1:0] line_len_i,
  input  logic [COL_W-1:0] active_len_i,
  input  logic [ROW_W-1:0] field_lines_i,
  input  logic [COL_W-1:0] vs_width_i,
  input  logic [COL_W-1:0] vs_offset_i,
  input  logic [PIX_W-1:0] pix_data_i,
  input  logic             pix_valid_i,
  output logic             pix_ready_o,
  output logic [BUS_W-1:0] disp_bus_o,
  output logic             hsync_no,
  output logic             vsync_no,
  output logic             drdy_no,
  output logic             field_odd_o
);
  tmg_cfg_t         cfg, shd;
  logic             run, odd;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;

  assign cfg.line_len   = line_len_i;
  assign cfg.active_len = active_len_i;
  assign cfg.rows       = field_lines_i;
  assign cfg.vs_wid     = vs_width_i;
  assign cfg.vs_off     = vs_offset_i;

  tmg_raster_cnt u_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .cfg_i (cfg),
    .run_o (run), .col_o (col), .row_o (row), .odd_o (odd), .shd_o (shd)
  );

  tmg_sync_gen u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (run), .col_i (col),
    .row_i (row), .odd_i (odd), .shd_i (shd),
    .hsync_no (hsync_no), .vsync_no (vsync_no), .field_odd_o (field_odd_o)
  );

  tmg_pix_path #(.BUS_LSB (BUS_LSB)) u_pix (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (run), .col_i (col),
    .act_len_i (shd.active_len), .pix_data_i (pix_data_i),
    .pix_valid_i (pix_valid_i), .pix_ready_o (pix_ready_o),
    .bus_o (disp_bus_o), .drdy_no (drdy_no)
  );
endmodule

// File: rtl/yuv_tmg_chk.sv
module yuv_tmg_chk #(
  parameter int unsigned BUS_W = 18,
  parameter int unsigned BUS_LSB = 10,
  parameter int unsigned PIX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [PIX_W-1:0] pix_data_i,
  input logic             pix_valid_i,
  input logic             pix_ready_o,
  input logic [BUS_W-1:0] disp_bus_o,
  input logic             hsync_no,
  input logic             vsync_no,
  input logic             drdy_no,
  input logic             field_odd_o
);
  p_hs_one_clk_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_no |=> hsync_no);

  p_data_in_active_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drdy_no |-> hsync_no);

  p_byte_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && pix_ready_o) |=>
      (!drdy_no && disp_bus_o[BUS_LSB +: PIX_W] == $past(pix_data_i)));

  p_idle_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drdy_no |-> (disp_bus_o == '0));

  p_odd_edges_meet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(vsync_no) && field_odd_o) |-> $fell(hsync_no));

  p_even_edges_apart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(vsync_no) && !field_odd_o) |-> hsync_no);
endmodule

bind yuv_field_timer yuv_tmg_chk #(
  .BUS_W (BUS_W), .BUS_LSB (BUS_LSB), .PIX_W (yuv_tmg_pkg::PIX_W)
) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .pix_data_i (pix_data_i),
  .pix_valid_i (pix_valid_i), .pix_ready_o (pix_ready_o),
  .disp_bus_o (disp_bus_o), .hsync_no (hsync_no), .vsync_no (vsync_no),
  .drdy_no (drdy_no), .field_odd_o (field_odd_o)
);

// File: tb/yuv_field_timer_tb_top.sv
module yuv_field_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int END_K      = 440;

  typedef struct packed {
    logic        hs;
    logic        vs;
    logic        dr;
    logic        par;
    logic [17:0] bus;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] line_len_i, active_len_i, vs_width_i, vs_offset_i;
  logic [10:0] field_lines_i;
  logic [7:0]  pix_data_i = '0;
  logic        pix_valid_i = 1'b0;
  logic        pix_ready_o, hsync_no, vsync_no, drdy_no, field_odd_o;
  logic [17:0] disp_bus_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int phase  = 0;
  exp_t q[$];

  // bench raster model
  int mh, mv, modd, mL, mA, mN, mW, mO;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  yuv_field_timer dut_i (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .line_len_i (line_len_i), .active_len_i (active_len_i),
    .field_lines_i (field_lines_i), .vs_width_i (vs_width_i),
    .vs_offset_i (vs_offset_i), .pix_data_i (pix_data_i),
    .pix_valid_i (pix_valid_i), .pix_ready_o (pix_ready_o),
    .disp_bus_o (disp_bus_o), .hsync_no (hsync_no), .vsync_no (vsync_no),
    .drdy_no (drdy_no), .field_odd_o (field_odd_o)
  );

  task automatic chk(input bit ok, input string req, input int k,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s k=%0d phase=%0d actual=%0h expected=%0h", req, k, phase, act, exp);
    end
  endtask

  task automatic load_cfg();
    mL = int'(line_len_i); mA = int'(active_len_i); mN = int'(field_lines_i);
    mW = int'(vs_width_i); mO = int'(vs_offset_i);
  endtask

  function automatic bit model_ready();
    return (mh >= 1) && (mh <= mA);
  endfunction

  // driver: expected outputs for the current raster position
  task automatic push_exp();
    exp_t e;
    int s, w;
    s = (modd != 0) ? 0 : ((mO == 0) ? 1 : mO);
    w = (mW == 0) ? 1 : mW;
    e.hs  = (mh == 0) ? 1'b0 : 1'b1;
    e.vs  = (mv == 0 && mh >= s && mh < s + w) ? 1'b0 : 1'b1;
    e.dr  = (model_ready() && pix_valid_i) ? 1'b0 : 1'b1;
    e.par = (modd != 0);
    e.bus = (e.dr == 1'b0) ? {pix_data_i, 10'b0} : 18'b0;
    q.push_back(e);
  endtask

  task automatic advance();
    if (mh == mL - 1) begin
      mh = 0;
      if (mv == mN - 1) begin
        mv = 0;
        modd = (modd != 0) ? 0 : 1;
        if (modd != 0) load_cfg();   // R10 capture at frame start only
      end else mv++;
    end else mh++;
  endtask

  // monitor: compare the item due one clock after its raster position
  task automatic monitor(input int k);
    exp_t e;
    string vtag;
    e = q.pop_front();
    vtag = e.par ? "R6 R8" : "R7 R8";
    if (phase == 2) vtag = {vtag, " R10"};
    chk(hsync_no == e.hs, phase == 2 ? "R2 R10" : "R2", k, hsync_no, e.hs);
    chk(vsync_no == e.vs, vtag, k, vsync_no, e.vs);
    chk(drdy_no == e.dr, "R5", k, drdy_no, e.dr);
    chk(disp_bus_o == e.bus, "R4", k, disp_bus_o, e.bus);
    chk(field_odd_o == e.par, "R9", k, field_odd_o, e.par);
  endtask

  initial begin
    line_len_i = 12'd12; active_len_i = 12'd6; field_lines_i = 11'd4;
    vs_width_i = 12'd3;  vs_offset_i = 12'd5;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(hsync_no == 1'b1, "R1", -1, hsync_no, 1);
    chk(vsync_no == 1'b1, "R1", -1, vsync_no, 1);
    chk(drdy_no == 1'b1, "R1", -1, drdy_no, 1);
    chk(disp_bus_o == 18'd0, "R1", -1, disp_bus_o, 0);
    chk(pix_ready_o == 1'b0, "R1", -1, pix_ready_o, 0);
    rst_ni = 1'b1;
    mh = 0; mv = 0; modd = 1;
    load_cfg();
    @(posedge clk_i);
    for (int k = 0; k < END_K; k++) begin
      @(negedge clk_i);
      if (k > 0) monitor(k - 1);
      // phase 1: gappy source; phase 2: mid-frame change (R10); phase 3: idle source
      if (k == 140) begin
        phase = 2;
        line_len_i = 12'd10; active_len_i = 12'd8; field_lines_i = 11'd3;
        vs_width_i = 12'd0;  vs_offset_i = 12'd0;
      end
      if (k == 192) phase = 1;
      if (k == 330) phase = 3;
      pix_valid_i = (phase == 3) ? 1'b0 : (phase == 2 || k >= 192) ? 1'b1 : ((k % 7) != 3);
      pix_data_i  = 8'(k) ^ 8'hA5;
      chk(pix_ready_o == model_ready(), "R3", k, pix_ready_o, model_ready());
      push_exp();
      advance();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule